// File: doc/BRIEF.md
# Byte-Wide Master/Slave SPI Shift Engine with Error Flags

This block moves one byte at a time over a four-wire serial link, in either direction. It acts as clock master or as a selected slave, depending on a mode bit in its control register. Software reaches it through a small register bus. A single-cycle write strobe or read strobe, with a 3-bit address, gives access to five registers: control, status, pin control, transmit data and receive data.

Bytes move most significant bit first in SPI mode 0. SCK idles low. Data is sampled on the rising edge and changed on the falling edge. As master, the block makes SCK by dividing the system clock by an even parameter. As slave, it passes the incoming SCK, slave-select and MOSI through a two-flop synchroniser and finds their edges on the system clock. Each pin has an output-enable, so the pad ring can reverse SCK, MOSI and MISO between modes. The slave-select pin is always an input.

The status register carries three flags. A ready flag says a new byte may be loaded. A collision flag records that a data register was touched during a byte. A multi-master flag records that another master pulled slave-select low. Reading the status register clears the two error flags.

Top module: `spi_ctrl`

## Requirements
- R1: After reset, control (address 0) reads 0x00, status (address 1) reads 0x01, pin control (address 2) reads 0x00 and receive data (address 4) reads 0x00. All output-enables are low, and unused register bits read as zero. Control bit 0 enables the block and control bit 1 selects master mode. Address 3 is transmit data.
- R2: In master mode, a write to transmit data starts a byte. SCK runs at the system clock divided by DIV. MOSI carries the byte MSB first and changes on falling SCK edges. MISO is sampled on rising edges, and the received byte is placed in the receive data register.
- R3: Status bit 0 (ready) is cleared by an accepted transmit data write. It is set once the eighth bit has shifted and the received byte has been latched.
- R4: A transmit data write or a receive data read while a byte is in progress sets status bit 2 (collision). A transmit data write made during a byte is discarded.
- R5: A status read clears status bits 2 and 1. If a set condition for a flag arrives in the same cycle as the read, the set wins.
- R6: In enabled master mode with pin control bit 2 set, a falling edge on the synchronised slave-select sets status bit 1 (multi-master). With pin control bit 2 clear, slave-select has no effect on that flag.
- R7: In master mode with pin control bit 0 clear, the MOSI enable drops when a byte completes. With bit 0 set, MOSI stays enabled after the byte and holds the level of the last bit sent.
- R8: In enabled master mode, SCK is enabled as an output, MOSI is enabled while a byte is in flight or held, and MISO is not driven. In slave mode, only MISO is driven, and only while slave-select is low. A disabled block drives nothing.
- R9: In slave mode with slave-select low, the block samples MOSI on each rising SCK edge and shifts on each falling edge. It presents the transmit byte MSB first on MISO and latches the received byte after eight bits.
- R10: In slave mode, raising slave-select in the middle of a byte aborts it. The receive register and the ready flag are left unchanged, and the next byte starts from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (status and receive side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_i | input | 1 | Serial clock from the pad (slave) |
| sck_o | output | 1 | Serial clock to the pad (master) |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI from the pad (slave) |
| mosi_o | output | 1 | MOSI to the pad (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the pad (master) |
| miso_o | output | 1 | MISO to the pad (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Active-low slave-select input |

## Verification
The assertions assume one register access per cycle, so a status read never falls in the same cycle as a transmit write or a receive read. The bench keeps to this because its bus tasks issue one strobe at a time. In slave mode, the assertions and the edge detection assume that SCK, MOSI and slave-select hold each level for several system clocks. The bench drives every serial level for six clocks. It also waits for ready before loading the next byte, so it never depends on an unplanned collision.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_STAT = 3'd1;
  localparam logic [2:0] ADR_PIN  = 3'd2;
  localparam logic [2:0] ADR_TXD  = 3'd3;
  localparam logic [2:0] ADR_RXD  = 3'd4;
  localparam int CTL_EN   = 0;
  localparam int CTL_MST  = 1;
  localparam int PIN_KEEP = 0;
  localparam int PIN_MMEN = 2;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          master_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          miso_i,
  input  logic          sck_s_i,
  input  logic          ss_s_i,
  input  logic          mosi_s_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          last_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(HALF + 1);
  localparam int BW   = $clog2(DW);

  logic [DW-1:0] shreg_q;
  logic [CW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic busy_q, done_q, sck_q, sck_d_q, samp_q, last_q;
  logic m_tick, rise, fall, abort, s_rise, s_fall;

  assign m_tick = busy_q && master_i && (div_q == CW'(HALF - 1));
  assign s_rise = en_i && !master_i && !ss_s_i && sck_s_i && !sck_d_q;
  assign s_fall = en_i && !master_i && !ss_s_i && !sck_s_i && sck_d_q && busy_q;
  assign rise   = master_i ? (m_tick && !sck_q) : s_rise;
  assign fall   = master_i ? (m_tick && sck_q) : s_fall;
  assign abort  = !master_i && busy_q && ss_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      div_q   <= '0;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      sck_d_q <= 1'b0;
      samp_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      done_q  <= 1'b0;
      if (load_i) begin
        shreg_q <= load_data_i;
        bit_q   <= '0;
        if (en_i && master_i) begin
          busy_q <= 1'b1;
          sck_q  <= 1'b0;
          div_q  <= '0;
        end
      end else if (abort) begin
        busy_q <= 1'b0;
        bit_q  <= '0;
      end else begin
        if (busy_q && master_i) div_q <= m_tick ? '0 : div_q + 1'b1;
        if (m_tick) sck_q <= !sck_q;
        if (rise) begin
          samp_q <= master_i ? miso_i : mosi_s_i;
          if (!master_i) busy_q <= 1'b1;
        end
        if (fall) begin
          last_q  <= shreg_q[DW-1];
          shreg_q <= {shreg_q[DW-2:0], samp_q};
          bit_q   <= bit_q + 1'b1;
          if (bit_q == BW'(DW - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            bit_q  <= '0;
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = shreg_q;
  assign sck_o  = sck_q;
  assign sdo_o  = shreg_q[DW-1];
  assign last_o = last_q;

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort && !load_i) |=> (!busy_q && !done_q && bit_q == '0));
  p_sck_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && master_i) |-> !sck_q);
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DIV = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  input  logic       ss_ni
);
  localparam int DW = 8;

  logic en_q, mst_q, keep_q, mmen_q, rdy_q, mm_q, col_q, ss_d_q;
  logic [DW-1:0] rxd_q, rx_w;
  logic [2:0] pin_s;
  logic sck_s, ss_s, mosi_s;
  logic busy, done, sdo, last, eng_sck;
  logic wr_tx, rd_rx, rd_st, col_evt, mm_evt, load;

  spi_ctrl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({mosi_i, ss_ni, sck_i}), .q_o(pin_s)
  );
  assign {mosi_s, ss_s, sck_s} = pin_s;

  spi_ctrl_shift #(.DW(DW), .DIV(DIV)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .master_i(mst_q),
    .load_i(load), .load_data_i(wdata_i), .miso_i(miso_i),
    .sck_s_i(sck_s), .ss_s_i(ss_s), .mosi_s_i(mosi_s),
    .busy_o(busy), .done_o(done), .rx_o(rx_w),
    .sck_o(eng_sck), .sdo_o(sdo), .last_o(last)
  );

  assign wr_tx   = wr_i && addr_i == ADR_TXD;
  assign rd_rx   = rd_i && addr_i == ADR_RXD;
  assign rd_st   = rd_i && addr_i == ADR_STAT;
  assign col_evt = busy && (wr_tx || rd_rx);
  assign load    = wr_tx && !busy;
  assign mm_evt  = en_q && mst_q && mmen_q && ss_d_q && !ss_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      keep_q <= 1'b0;
      mmen_q <= 1'b0;
      rdy_q  <= 1'b1;
      mm_q   <= 1'b0;
      col_q  <= 1'b0;
      ss_d_q <= 1'b1;
      rxd_q  <= '0;
    end else begin
      ss_d_q <= ss_s;
      if (wr_i && addr_i == ADR_CTRL) begin
        en_q  <= wdata_i[CTL_EN];
        mst_q <= wdata_i[CTL_MST];
      end
      if (wr_i && addr_i == ADR_PIN) begin
        keep_q <= wdata_i[PIN_KEEP];
        mmen_q <= wdata_i[PIN_MMEN];
      end
      if (load)      rdy_q <= 1'b0;
      else if (done) rdy_q <= 1'b1;
      if (done) rxd_q <= rx_w;
      // set beats the read-clear
      if (col_evt)    col_q <= 1'b1;
      else if (rd_st) col_q <= 1'b0;
      if (mm_evt)     mm_q <= 1'b1;
      else if (rd_st) mm_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CTRL: begin
        rdata_o[CTL_EN]  = en_q;
        rdata_o[CTL_MST] = mst_q;
      end
      ADR_STAT: rdata_o[2:0] = {col_q, mm_q, rdy_q};
      ADR_PIN: begin
        rdata_o[PIN_KEEP] = keep_q;
        rdata_o[PIN_MMEN] = mmen_q;
      end
      ADR_RXD: rdata_o = rxd_q;
      default: rdata_o = '0;
    endcase
  end

  assign sck_o     = eng_sck;
  assign sck_oe_o  = en_q && mst_q;
  assign mosi_o    = busy ? sdo : last;
  assign mosi_oe_o = en_q && mst_q && (busy || keep_q);
  assign miso_o    = sdo;
  assign miso_oe_o = en_q && !mst_q && !ss_s;

  p_ready_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !rdy_q);
  p_ready_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !load) |=> rdy_q);
  p_col_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_tx) |=> (col_q && $stable(rdy_q)));
  p_col_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> !col_q);
  p_mm_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_evt && rd_st) |=> mm_q);
  p_mm_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mmen_q && !mm_q) |=> !mm_q);
  p_dir_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miso_oe_o && (sck_oe_o || mosi_oe_o)));
endmodule

// File: tb/spi_ctrl_bench.sv
`timescale 1ns/1ps
module spi_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1;
  logic sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
  logic [7:0] sl_tx = '0, sl_rx = '0;
  int n_vec = 0, n_err = 0, per_err = 0;
  realtime t_rise = 0;

  always #2 clk = ~clk;

  spi_ctrl u_spi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata),
    .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(sl_tx[7]), .miso_o(miso_out), .miso_oe_o(miso_oe),
    .ss_ni(ss_n)
  );

  // external slave model for master-mode tests
  always @(posedge sck_out) begin
    sl_rx = {sl_rx[6:0], mosi_out};
    if (t_rise != 0 && ($realtime - t_rise) != 16.0) per_err++;
    t_rise = $realtime;
  end
  always @(negedge sck_out) sl_tx = {sl_tx[6:0], 1'b0};

  task automatic chk(input string rq, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #0.5 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      bus_rd(3'd1, s);
      if (s[0]) return;
    end
    chk("R3 ready timeout", 0, 1);
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sb);
    sl_tx = sb; sl_rx = '0; t_rise = 0;
    bus_wr(3'd3, tx);
    wait_ready();
  endtask

  task automatic s_bits(input logic [7:0] m, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi_in = m[i];
      repeat (6) @(negedge clk);
      got[i] = miso_out;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d, got, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    bus_rd(3'd1, d); chk("R1 status", d, 8'h01);
    bus_rd(3'd2, d); chk("R1 pin", d, 8'h00);
    bus_rd(3'd4, d); chk("R1 rxd", d, 8'h00);
    chk("R1 oe", {sck_oe, mosi_oe, miso_oe}, 0);

    // master sweep, keep off
    bus_wr(3'd0, 8'h03);
    bus_rd(3'd0, d); chk("R1 ctrl rb", d, 8'h03);
    chk("R8 master sck_oe", sck_oe, 1);
    chk("R8 master miso_oe", miso_oe, 0);
    for (int b = 0; b < 256; b++) begin
      exp = 8'((b * 7 + 3) % 256);
      m_xfer(8'(b), exp);
      bus_rd(3'd4, d); chk("R2 master rx", d, exp);
      chk("R2 master mosi", sl_rx, b);
      chk("R7 mosi released", mosi_oe, 0);
    end
    chk("R2 sck period", per_err, 0);

    // R7 keep
    bus_wr(3'd2, 8'h01);
    m_xfer(8'h01, 8'h00);
    chk("R7 keep oe", mosi_oe, 1); chk("R7 keep level1", mosi_out, 1);
    m_xfer(8'hFE, 8'h00);
    chk("R7 keep level0", mosi_out, 0);
    bus_wr(3'd2, 8'h00);

    // R4/R5 collisions
    sl_tx = 8'h96; sl_rx = '0; t_rise = 0;
    bus_wr(3'd3, 8'h3C);
    chk("R8 mosi oe busy", mosi_oe, 1);
    bus_wr(3'd3, 8'hFF);
    bus_rd(3'd1, d); chk("R4 col on tx write", d, 8'h04);
    bus_rd(3'd1, d); chk("R5 col cleared", d, 8'h00);
    bus_rd(3'd4, d);
    bus_rd(3'd1, d); chk("R4 col on rx read", d, 8'h04);
    wait_ready();
    chk("R4 write discarded", sl_rx, 8'h3C);
    bus_rd(3'd4, d); chk("R4 rx after col", d, 8'h96);
    bus_rd(3'd1, d); chk("R3 status after", d, 8'h01);

    // R6 multi-master
    ss_n = 1'b0; repeat (6) @(negedge clk);
    bus_rd(3'd1, d); chk("R6 detect off ignored", d, 8'h01);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    bus_wr(3'd2, 8'h04);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    bus_rd(3'd1, d); chk("R6 mm set", d, 8'h03);
    bus_rd(3'd1, d); chk("R5 mm cleared", d, 8'h01);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    bus_wr(3'd2, 8'h00);

    // R8 disabled
    bus_wr(3'd0, 8'h00);
    chk("R8 disabled oe", {sck_oe, mosi_oe, miso_oe}, 0);

    // slave sweep
    bus_wr(3'd0, 8'h01);
    chk("R8 slave unselected", {sck_oe, mosi_oe, miso_oe}, 0);
    for (int b = 0; b < 256; b++) begin
      bus_wr(3'd3, 8'(b) ^ 8'h5A);
      ss_n = 1'b0; repeat (6) @(negedge clk);
      if (b == 0) chk("R8 slave selected", {sck_oe, mosi_oe, miso_oe}, 1);
      s_bits(8'(b), 8, got);
      ss_n = 1'b1; repeat (6) @(negedge clk);
      bus_rd(3'd4, d); chk("R9 slave rx", d, b);
      chk("R9 slave miso", got, 8'(b) ^ 8'h5A);
      bus_rd(3'd1, d); chk("R3 slave ready", d, 8'h01);
    end

    // R10 abort
    bus_wr(3'd3, 8'hC3);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    s_bits(8'hF0, 4, got);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    bus_rd(3'd1, d); chk("R10 ready kept", d, 8'h00);
    bus_rd(3'd4, d); chk("R10 rx kept", d, 8'hFF);
    bus_wr(3'd3, 8'hC3);
    ss_n = 1'b0; repeat (6) @(negedge clk);
    s_bits(8'h81, 8, got);
    ss_n = 1'b1; repeat (6) @(negedge clk);
    bus_rd(3'd4, d); chk("R10 restart rx", d, 8'h81);
    chk("R10 restart miso", got, 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule